// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt inputs, picks the most urgent one that is allowed to interrupt, and raises a single interrupt line toward a processor. The processor answers with a one-cycle acknowledge strobe. One cycle later the block returns an 8-bit vector, formed from a programmable base plus the number of the input being served. The block then remembers that level as in service until software retires it with a specific end-of-interrupt command, unless automatic end-of-interrupt is enabled.

Software programs the block through a byte-wide register bus with a 2-bit address. Address bit 0 selects the command port (0) or the data port (1). Address bit 1, when set, selects the trigger-mode register, which picks edge or level sensitivity for each input. A configuration state machine (`cfg_state_t`) moves through these states:

- `CFG_RUN`, the normal state.
- `CFG_W2`, which waits for the vector base.
- `CFG_W3`, which waits for the cascade word.
- `CFG_W4`, which waits for the mode word.

Its transitions are:

- any state → `CFG_W2` on an init command;
- `CFG_W2` → `CFG_W3` on a data write;
- `CFG_W3` → `CFG_W4` on a data write when the mode word was requested;
- `CFG_W3` → `CFG_RUN` on a data write when it was not;
- `CFG_W4` → `CFG_RUN` on a data write.

An acknowledge state machine (`ack_state_t`) has two states. `ACK_IDLE` moves to `ACK_RAISED` when an eligible request exists. `ACK_RAISED` moves back to `ACK_IDLE` on an acknowledge. The interrupt output is high exactly while the acknowledge machine is in `ACK_RAISED`.

Cascading is reduced to a stored cascade word that is presented on an output. For a master, the word is the mask of inputs that have slaves attached. For a slave, it is the slave's identity.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the interrupt output is low, the mask register reads 0xFF, the in-service register is clear, command-port reads return the request register, automatic end-of-interrupt is off, and the trigger register reads 0x00 (all inputs edge-triggered).
- R2: A command-port write with bit 4 set starts initialization. It clears the in-service register and points command-port reads at the request register. The next data-port writes are taken as the vector base, then the cascade word (shown on `link_cfg`), then the mode word, but the mode word is expected only when bit 0 of the init command was 1. The following data write loads the mask register.
- R3: The vector returned on an acknowledge is the vector base plus the number (0 to 7) of the input served.
- R4: Bit 1 of the mode word enables automatic end-of-interrupt. In that mode, an acknowledge sets no in-service bit. Otherwise the served level's in-service bit is set.
- R5: A command write of 0x0A makes command-port reads return the request register. A command write of 0x0B makes them return the in-service register. The selection persists until changed.
- R6: A command write of 0x60+n (n = 0..7) clears in-service bit n only.
- R7: Outside initialization, a data-port write loads the mask register and a data-port read returns it. A masked input never raises the interrupt output. Request bits are still recorded while masked.
- R8: If the request that raised the interrupt output is gone at acknowledge time, the vector is base+7 and no in-service bit is set.
- R9: Address bit 1 selects the trigger register (read and write). A 1 bit selects level mode, where the request bit follows the input. A 0 bit selects edge mode, where a rising edge sets the request bit and an acknowledge of that level clears it.
- R10: Priority is fixed with input 0 highest. A request interrupts only if its level is numerically lower than every level in service.
- R11: The interrupt output rises on the clock after an eligible request appears and stays high until an acknowledge. The vector is valid one cycle after the acknowledge. An acknowledge while the interrupt output is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Bit 0: command (0) or data (1) port; bit 1: trigger register |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq_in | input | 8 | Interrupt request inputs, input 0 highest priority |
| int_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | One-cycle acknowledge strobe |
| ack_valid | output | 1 | Vector valid, one cycle after an accepted acknowledge |
| ack_vector | output | 8 | Returned vector |
| link_cfg | output | 8 | Stored cascade word |

## Verification
The bench uses single edge-triggered inputs to separate edge capture from level following. It also uses an input that is held high after its acknowledge, to show that an edge request is not re-armed.

Nested requests drive the priority checks. An input below the one in service must stay silent. An input above it must break through. After the in-service bits are retired, the waiting lower input must then be delivered.

A request withdrawn before the acknowledge tells a real vector apart from the base+7 spurious answer. Two init sequences, one with the mode word and one without, show whether the fourth data write is taken as the mode word or as a mask load.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
    localparam int PIC_N   = 8;               // number of request inputs
    localparam int PIC_W   = 8;               // bus and vector width
    localparam int PIC_LW  = $clog2(PIC_N);   // level number width
    localparam int PIC_LW1 = PIC_LW + 1;      // level width with a "none" code
    localparam int PIC_AW  = 2;               // register address width

    typedef enum logic [1:0] {
        CFG_RUN,
        CFG_W2,
        CFG_W3,
        CFG_W4
    } cfg_state_t;

    typedef enum logic {
        ACK_IDLE,
        ACK_RAISED
    } ack_state_t;
endpackage

// File: rtl/pic8_cfg.sv
module pic8_cfg
    import pic8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIC_AW-1:0] addr,
    input  logic              wr,
    input  logic [PIC_W-1:0]  wdata,
    output logic [PIC_N-1:0]  mask_q,
    output logic [PIC_N-1:0]  trig_q,
    output logic [PIC_W-1:0]  base_q,
    output logic [PIC_W-1:0]  link_q,
    output logic              aeoi_q,
    output logic              rd_isr_q,
    output logic              init_clr,
    output logic              eoi_stb,
    output logic [PIC_LW-1:0] eoi_lvl
);
    cfg_state_t st_q, st_nx;
    logic       need4_q;
    logic       cmd_wr, dat_wr, trg_wr, start;

    assign cmd_wr = wr && (addr == 2'b00);
    assign dat_wr = wr && (addr == 2'b01);
    assign trg_wr = wr && addr[1];
    assign start  = cmd_wr && wdata[4];

    always_comb begin
        st_nx = st_q;
        if (start) begin
            st_nx = CFG_W2;
        end else if (dat_wr) begin
            unique case (st_q)
                CFG_RUN: st_nx = CFG_RUN;
                CFG_W2:  st_nx = CFG_W3;
                CFG_W3:  st_nx = need4_q ? CFG_W4 : CFG_RUN;
                CFG_W4:  st_nx = CFG_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CFG_RUN;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '1;
            trig_q   <= '0;
            base_q   <= '0;
            link_q   <= '0;
            aeoi_q   <= 1'b0;
            rd_isr_q <= 1'b0;
            need4_q  <= 1'b0;
        end else begin
            if (trg_wr) trig_q <= wdata;
            if (start) begin
                need4_q  <= wdata[0];
                rd_isr_q <= 1'b0;
            end else if (cmd_wr && (st_q == CFG_RUN) && (wdata[4:3] == 2'b01) && wdata[1]) begin
                rd_isr_q <= wdata[0];
            end
            if (dat_wr) begin
                unique case (st_q)
                    CFG_RUN: mask_q <= wdata;
                    CFG_W2:  base_q <= wdata;
                    CFG_W3: begin
                        link_q <= wdata;
                        if (!need4_q) aeoi_q <= 1'b0;
                    end
                    CFG_W4:  aeoi_q <= wdata[1];
                endcase
            end
        end
    end

    always_comb begin
        init_clr = start;
        eoi_stb  = cmd_wr && (st_q == CFG_RUN) && (wdata[7:3] == 5'b01100);
        eoi_lvl  = wdata[PIC_LW-1:0];
    end
endmodule

// File: rtl/pic8_irr.sv
module pic8_irr
    import pic8_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIC_N-1:0] irq_in,
    input  logic [PIC_N-1:0] trig,
    input  logic [PIC_N-1:0] clr_vec,
    output logic [PIC_N-1:0] irr
);
    logic [PIC_N-1:0] prev_q, edge_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            edge_q <= '0;
        end else begin
            prev_q <= irq_in;
            edge_q <= ((edge_q & ~clr_vec) | (irq_in & ~prev_q)) & ~trig;
        end
    end

    for (genvar g = 0; g < PIC_N; g++) begin : g_bit
        assign irr[g] = trig[g] ? irq_in[g] : edge_q[g];
    end
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio
    import pic8_pkg::*;
(
    input  logic [PIC_N-1:0]  pend,
    input  logic [PIC_N-1:0]  isr,
    output logic              hit,
    output logic [PIC_LW-1:0] lvl
);
    always_comb begin
        logic               found;
        logic [PIC_LW-1:0]  cand;
        logic [PIC_LW1-1:0] top_isr;
        found   = 1'b0;
        cand    = '0;
        top_isr = PIC_LW1'(PIC_N);
        for (int i = PIC_N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                cand  = PIC_LW'(i);
            end
            if (isr[i]) top_isr = PIC_LW1'(i);
        end
        hit = found && ({1'b0, cand} < top_isr);
        lvl = cand;
    end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIC_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [PIC_W-1:0]  reg_wdata,
    output logic [PIC_W-1:0]  reg_rdata,
    input  logic [PIC_N-1:0]  irq_in,
    output logic              int_out,
    input  logic              ack,
    output logic              ack_valid,
    output logic [PIC_W-1:0]  ack_vector,
    output logic [PIC_W-1:0]  link_cfg
);
    ack_state_t        st_q, st_nx;
    logic [PIC_N-1:0]  mask_q, trig_q, irr, pend_vec, isr_q, set_vec, clr_vec, eoi_vec;
    logic [PIC_W-1:0]  base_q, link_q;
    logic              aeoi_q, rd_isr_q, init_clr, eoi_stb, hit, ack_take;
    logic [PIC_LW-1:0] eoi_lvl, lvl;

    pic8_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
        .mask_q(mask_q), .trig_q(trig_q), .base_q(base_q), .link_q(link_q),
        .aeoi_q(aeoi_q), .rd_isr_q(rd_isr_q), .init_clr(init_clr),
        .eoi_stb(eoi_stb), .eoi_lvl(eoi_lvl)
    );

    pic8_irr u_irr (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig(trig_q),
        .clr_vec(clr_vec), .irr(irr)
    );

    assign pend_vec = irr & ~mask_q;

    pic8_prio u_prio (.pend(pend_vec), .isr(isr_q), .hit(hit), .lvl(lvl));

    assign ack_take = (st_q == ACK_RAISED) && ack;
    assign clr_vec  = (ack_take && hit) ? (PIC_N'(1) << lvl) : '0;
    assign set_vec  = aeoi_q ? '0 : clr_vec;
    assign eoi_vec  = eoi_stb ? (PIC_N'(1) << eoi_lvl) : '0;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ACK_IDLE:   if (hit) st_nx = ACK_RAISED;
            ACK_RAISED: if (ack) st_nx = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ACK_IDLE;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q      <= '0;
            ack_valid  <= 1'b0;
            ack_vector <= '0;
        end else begin
            ack_valid <= ack_take;
            if (ack_take)
                ack_vector <= base_q + PIC_W'(hit ? lvl : PIC_LW'(PIC_N - 1));
            if (init_clr) isr_q <= '0;
            else          isr_q <= (isr_q & ~eoi_vec) | set_vec;
        end
    end

    always_comb begin
        int_out  = (st_q == ACK_RAISED);
        link_cfg = link_q;
        if (reg_addr[1])      reg_rdata = trig_q;
        else if (reg_addr[0]) reg_rdata = mask_q;
        else                  reg_rdata = rd_isr_q ? isr_q : irr;
    end
endmodule

// File: rtl/pic8_sva.sv
module pic8_sva
    import pic8_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              int_out,
    input logic              ack,
    input logic              ack_valid,
    input logic [PIC_W-1:0]  ack_vector,
    input logic [PIC_W-1:0]  base_q,
    input logic [PIC_N-1:0]  pend_vec,
    input logic [PIC_N-1:0]  isr_q,
    input logic [PIC_N-1:0]  set_vec,
    input logic              aeoi_q,
    input logic              eoi_stb,
    input logic [PIC_LW-1:0] eoi_lvl
);
    AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_out) |-> ($past(pend_vec) != '0)); // R7
    AST_ACK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out) |=> ack_valid); // R11
    AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_out) |=> !ack_valid); // R11
    AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (PIC_W'(ack_vector - base_q) < PIC_W'(PIC_N))); // R3
    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_stb && (set_vec == '0)) |=> !isr_q[$past(eoi_lvl)]); // R6
    AST_AEOI_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out && aeoi_q) |=> ((isr_q & ~$past(isr_q)) == '0)); // R4
endmodule

bind pic8_ctrl pic8_sva u_sva (
    .clk(clk), .rst_n(rst_n), .int_out(int_out), .ack(ack), .ack_valid(ack_valid),
    .ack_vector(ack_vector), .base_q(base_q), .pend_vec(pend_vec), .isr_q(isr_q),
    .set_vec(set_vec), .aeoi_q(aeoi_q), .eoi_stb(eoi_stb), .eoi_lvl(eoi_lvl)
);

// File: tb/tb_pic8_ctrl.sv
module tb_pic8_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'b00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] irq_in = 8'h00;
    logic       int_out;
    logic       ack = 1'b0;
    logic       ack_valid;
    logic [7:0] ack_vector;
    logic [7:0] link_cfg;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    pic8_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
        .int_out(int_out), .ack(ack), .ack_valid(ack_valid),
        .ack_vector(ack_vector), .link_cfg(link_cfg)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #2;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic do_ack(input logic [7:0] exp, input string tag);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        #1;
        chk({tag, " valid"}, {7'd0, ack_valid}, 8'h01);
        chk({tag, " vector"}, ack_vector, exp);
    endtask

    task automatic t_reset;
        chk("R1 int low", {7'd0, int_out}, 8'h00);
        rd(2'b01, 8'hFF, "R1 mask all set");
        rd(2'b00, 8'h00, "R1 request reg clear");
        rd(2'b10, 8'h00, "R1 trigger edge");
        wr(2'b00, 8'h0B);
        rd(2'b00, 8'h00, "R1 in-service clear");
        wr(2'b00, 8'h0A);
    endtask

    task automatic t_init;
        wr(2'b00, 8'h11); wr(2'b01, 8'h20); wr(2'b01, 8'h04); wr(2'b01, 8'h01);
        #1 chk("R2 cascade word", link_cfg, 8'h04);
        rd(2'b01, 8'hFF, "R2 mask kept by init");
        wr(2'b01, 8'h00);
        rd(2'b01, 8'h00, "R7 mask write");
    endtask

    task automatic t_edge_nest;
        @(negedge clk) irq_in = 8'h08;
        idle(3);
        chk("R11 int raised", {7'd0, int_out}, 8'h01);
        rd(2'b00, 8'h08, "R9 edge request");
        do_ack(8'h23, "R3 level3");
        idle(2);
        chk("R9 edge cleared int", {7'd0, int_out}, 8'h00);
        rd(2'b00, 8'h00, "R9 edge request cleared");
        wr(2'b00, 8'h0B);
        rd(2'b00, 8'h08, "R5 isr select");
        @(negedge clk) irq_in = 8'h28;
        idle(3);
        chk("R10 lower blocked", {7'd0, int_out}, 8'h00);
        @(negedge clk) irq_in = 8'h2A;
        idle(3);
        chk("R10 higher nests", {7'd0, int_out}, 8'h01);
        do_ack(8'h21, "R10 nested vector");
        rd(2'b00, 8'h0A, "R4 isr nested");
        wr(2'b00, 8'h61);
        rd(2'b00, 8'h08, "R6 eoi one bit");
        idle(2);
        chk("R10 still blocked", {7'd0, int_out}, 8'h00);
        wr(2'b00, 8'h63);
        idle(3);
        chk("R10 lower released", {7'd0, int_out}, 8'h01);
        do_ack(8'h25, "R10 lower vector");
        wr(2'b00, 8'h65);
        rd(2'b00, 8'h00, "R6 isr empty");
        wr(2'b00, 8'h0A);
        rd(2'b00, 8'h00, "R5 irr select");
        @(negedge clk) irq_in = 8'h00;
    endtask

    task automatic t_mask;
        wr(2'b01, 8'h01);
        @(negedge clk) irq_in = 8'h01;
        idle(4);
        chk("R7 masked silent", {7'd0, int_out}, 8'h00);
        rd(2'b00, 8'h01, "R7 request recorded");
        wr(2'b01, 8'h00);
        idle(2);
        chk("R7 unmask raises", {7'd0, int_out}, 8'h01);
        do_ack(8'h20, "R3 level0");
        wr(2'b00, 8'h60);
        @(negedge clk) irq_in = 8'h00;
    endtask

    task automatic t_level_spurious;
        wr(2'b10, 8'h40);
        rd(2'b10, 8'h40, "R9 trigger readback");
        wr(2'b01, 8'h40);
        @(negedge clk) irq_in = 8'h40;
        idle(1);
        rd(2'b00, 8'h40, "R9 level follows high");
        @(negedge clk) irq_in = 8'h00;
        idle(1);
        rd(2'b00, 8'h00, "R9 level follows low");
        wr(2'b01, 8'h00);
        @(negedge clk) irq_in = 8'h40;
        idle(2);
        chk("R11 level raise", {7'd0, int_out}, 8'h01);
        @(negedge clk) irq_in = 8'h00;
        idle(2);
        chk("R11 held until ack", {7'd0, int_out}, 8'h01);
        do_ack(8'h27, "R8 spurious");
        wr(2'b00, 8'h0B);
        rd(2'b00, 8'h00, "R8 no isr bit");
        wr(2'b10, 8'h00);
    endtask

    task automatic t_reinit;
        @(negedge clk) irq_in = 8'h10;
        idle(3);
        do_ack(8'h24, "R3 level4");
        rd(2'b00, 8'h10, "R4 isr set normal");
        @(negedge clk) irq_in = 8'h00;
        wr(2'b00, 8'h11); wr(2'b01, 8'h28); wr(2'b01, 8'h04); wr(2'b01, 8'h03);
        wr(2'b00, 8'h0B);
        rd(2'b00, 8'h00, "R2 init clears isr");
        @(negedge clk) irq_in = 8'h04;
        idle(3);
        do_ack(8'h2A, "R3 new base");
        rd(2'b00, 8'h00, "R4 auto eoi");
        @(negedge clk) irq_in = 8'h00;
        wr(2'b00, 8'h10); wr(2'b01, 8'h30); wr(2'b01, 8'h02);
        #1 chk("R2 cascade slave id", link_cfg, 8'h02);
        wr(2'b01, 8'hF0);
        rd(2'b01, 8'hF0, "R2 no mode word");
        @(negedge clk) irq_in = 8'h01;
        idle(3);
        do_ack(8'h30, "R2 base without mode");
        wr(2'b00, 8'h0B);
        rd(2'b00, 8'h01, "R4 auto eoi off");
        wr(2'b00, 8'h60);
        @(negedge clk) irq_in = 8'h00;
    endtask

    task automatic t_stray_ack;
        idle(2);
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
        #1 chk("R11 stray ack ignored", {7'd0, ack_valid}, 8'h00);
        rd(2'b00, 8'h00, "R11 isr untouched");
    endtask

    initial begin
        idle(2);
        #3 rst_n = 1'b1;
        idle(1);
        t_reset;
        t_init;
        t_edge_nest;
        t_mask;
        t_level_spurious;
        t_reinit;
        t_stray_ack;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule